// File: doc/BRIEF.md
# Bit-Serial Adder with Stored Carry

This block adds two WIDTH-bit unsigned operands (eight bits by default) one bit position per clock. It uses a single full-adder cell. A start pulse captures both operands in parallel into two shift registers and clears the carry flip-flop. On each following cycle, the least significant remaining bit of each operand goes through the full adder. The carry produced is held in a flip-flop and becomes the carry into the next bit position. Each sum bit enters the top of a result shift register, so the low sum bit arrives first and ends up at bit 0 after WIDTH shifts.

When the last bit has been added, the block raises a one-cycle completion pulse. The result and the final carry then stay unchanged until another addition is started. A separate carry-clear input zeroes the stored carry while the block is idle. A new start pulse always begins a fresh addition, including one that arrives in the middle of an addition.

Top module: `serial_adder`

## Requirements
- R1: After reset, `sum` is 0, `carry_out` is 0, `busy` is 0 and `done` is 0.
- R2: A clock edge with `start` high captures `x_in` and `y_in`, clears the stored carry, and sets `busy` to 1 on the next cycle with `done` at 0.
- R3: One bit position is added per clock, least significant first. After the first add cycle, `sum[WIDTH-1]` holds bit 0 of the result.
- R4: `done` rises exactly WIDTH clock edges after the edge that sampled `start`, and at that point `busy` is 0.
- R5: While `done` is high, `sum` equals (x_in + y_in) mod 2^WIDTH and `carry_out` equals bit WIDTH of the full sum, for the operands that were captured.
- R6: `done` is high for exactly one cycle. While the block is idle and `start` is low, `sum` and `carry_out` do not change, except as R7 describes.
- R7: When the block is idle and `start` is low, `carry_clr` high at a clock edge forces `carry_out` to 0 and leaves `sum` unchanged.
- R8: `carry_clr` has no effect while `busy` is high. The result and final carry are the same as without it.
- R9: `start` while `busy` is high abandons the current addition and restarts with the newly presented operands. `done` then follows WIDTH edges after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture operands and begin an addition |
| carry_clr | input | 1 | Clear the stored carry while idle |
| x_in | input | WIDTH | First operand |
| y_in | input | WIDTH | Second operand |
| sum | output | WIDTH | Result shift register |
| carry_out | output | 1 | Stored carry; the final carry after completion |
| busy | output | 1 | An addition is in progress |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
The bound checker checks the following properties on every cycle:
- `busy` follows `start`.
- `done` lasts one cycle and never overlaps `busy`.
- `done` comes after exactly WIDTH busy cycles, measured by a counter in the checker.
- `sum` and `carry_out` hold while idle.
- An idle carry clear zeroes `carry_out`.

Whether the arithmetic is correct is shown only by the bench's operand scenarios. These include the all-ones carry chain, carry clears applied during a run, the bit-order check after the first add cycle, and a restart in mid-addition.

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             carry_clr,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             busy,
  output logic             done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] xs, ys, acc;
  logic [CW-1:0]    pos;
  logic             cy, run, fin;
  logic             fa_s, fa_c;

  assign fa_s = xs[0] ^ ys[0] ^ cy;
  assign fa_c = (xs[0] & ys[0]) | (cy & (xs[0] ^ ys[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs  <= '0;
      ys  <= '0;
      acc <= '0;
      pos <= '0;
      cy  <= 1'b0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        xs  <= x_in;
        ys  <= y_in;
        cy  <= 1'b0;
        pos <= '0;
        run <= 1'b1;
      end else if (run) begin
        xs  <= xs >> 1;
        ys  <= ys >> 1;
        acc <= {fa_s, acc[WIDTH-1:1]};
        cy  <= fa_c;
        pos <= pos + 1'b1;
        if (pos == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end else if (carry_clr) begin
        cy <= 1'b0;
      end
    end
  end

  assign sum       = acc;
  assign carry_out = cy;
  assign busy      = run;
  assign done      = fin;
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             carry_clr,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             busy,
  input logic             done
);
  localparam int LW = $clog2(WIDTH + 1) + 1;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_len <= '0;
    else if (start)                 run_len <= '0;
    else if (busy && run_len < LW'(WIDTH + 1)) run_len <= run_len + 1'b1;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done)); // R2
  AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == LW'(WIDTH) && !busy)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sum)); // R6
  AST_IDLE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !carry_clr) |=> $stable(carry_out)); // R6
  AST_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && carry_clr) |=> !carry_out); // R7
endmodule

bind serial_adder serial_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .carry_clr(carry_clr),
  .sum(sum), .carry_out(carry_out), .busy(busy), .done(done)
);

// File: tb/serial_adder_bench.sv
`timescale 1ns/1ps
module serial_adder_bench;
  localparam int W = 8;
  localparam int NV = 8;
  localparam logic [2*W-1:0] VEC [0:NV-1] = '{
    16'h0000, 16'h0101, 16'hFF01, 16'hFFFF,
    16'h5AA5, 16'h8080, 16'h7F01, 16'h3C4D
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, carry_clr = 1'b0;
  logic [W-1:0] x_in = '0, y_in = '0, sum;
  logic carry_out, busy, done;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  serial_adder #(.WIDTH(W)) u_serial_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .carry_clr(carry_clr),
    .x_in(x_in), .y_in(y_in), .sum(sum), .carry_out(carry_out),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_run(input logic [W-1:0] a, input logic [W-1:0] b, input logic clr_in_run);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    @(negedge clk); x_in = a; y_in = b; start = 1'b1;
    @(negedge clk); start = 1'b0; carry_clr = clr_in_run;
    check("R2 busy", {31'b0, busy}, 32'd1);
    @(negedge clk);
    check("R3 first bit", {31'b0, sum[W-1]}, {31'b0, full[0]});
    repeat (W - 2) @(negedge clk);
    check("R4 done early", {31'b0, done}, 32'd0);
    @(negedge clk); carry_clr = 1'b0;
    check("R4 done", {31'b0, done}, 32'd1);
    check("R4 busy low", {31'b0, busy}, 32'd0);
    check(clr_in_run ? "R8 sum" : "R5 sum", {24'b0, sum}, {24'b0, full[W-1:0]});
    check(clr_in_run ? "R8 carry" : "R5 carry", {31'b0, carry_out}, {31'b0, full[W]});
    @(negedge clk);
    check("R6 pulse", {31'b0, done}, 32'd0);
    check("R6 hold", {24'b0, sum}, {24'b0, full[W-1:0]});
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    check("R1 sum", {24'b0, sum}, 32'd0);
    check("R1 flags", {29'b0, carry_out, busy, done}, 32'd0);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) add_run(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0);

    add_run(8'hFF, 8'hFF, 1'b1);
    // R7: idle clear zeroes the carry, keeps the sum
    @(negedge clk); carry_clr = 1'b1;
    @(negedge clk); carry_clr = 1'b0;
    check("R7 carry", {31'b0, carry_out}, 32'd0);
    check("R7 sum", {24'b0, sum}, 32'hFE);
    repeat (3) @(negedge clk);
    check("R6 idle hold", {23'b0, carry_out, sum}, 32'hFE);

    // R9: restart mid-addition
    @(negedge clk); x_in = 8'hFF; y_in = 8'hFF; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    x_in = 8'h12; y_in = 8'h34; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (W - 1) @(negedge clk);
    check("R9 no early done", {31'b0, done}, 32'd0);
    @(negedge clk);
    check("R9 done", {31'b0, done}, 32'd1);
    check("R9 sum", {23'b0, carry_out, sum}, 32'h046);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule